// File: doc/BRIEF.md
# I2C Master Data Buffer

This block is the four-byte staging store that sits between a byte-wide register port and an I2C master engine. Software pushes bytes to be sent by writing the buffer and takes received bytes out by reading it; every read removes the oldest byte, so the buffer behaves as a small FIFO with the head always visible at the read-data output. After a receive transfer the engine loads the received bytes in one cycle together with the count of bytes moved.

Two status outputs report that the buffer holds at least one byte and that it holds four. A flush input empties the store in one cycle. Priority within a cycle is: flush, then engine load, then the CPU access. Within a CPU access a pop takes effect before a push.

Top module: `i2c_mdbuf`

## Requirements
- R1: After reset the buffer is empty, `has_data` and `full` are 0 and `cpu_rdata` is 0xFF.
- R2: Bytes pushed by `cpu_wr` are returned by `cpu_rd` in the order they were written; `cpu_rdata` shows the oldest byte during the cycle in which `cpu_rd` is high.
- R3: `has_data` rises with the first accepted push into an empty buffer and falls when the last byte is popped.
- R4: `full` rises with the fourth held byte and falls when a byte is popped from a full buffer.
- R5: A push into a full buffer with no pop in the same cycle is dropped; the stored bytes and `full` are unchanged.
- R6: While the buffer is empty `cpu_rdata` is 0xFF, and a pop changes nothing.
- R7: `flush` (and reset) empties the buffer, zeroes all entries and clears both flags; the next push lands at the head.
- R8: An engine load with count N (N above 4 is taken as 4) leaves the first N bytes of `eng_data` (byte k at bits [8k+7:8k]) as the buffer content, byte 0 first; `has_data` is set when N is at least 1 and `full` when N is 4.
- R9: A pop and a push in the same cycle apply the pop first, then the push; the flags show the net result (a full buffer stays full, a one-byte or empty buffer ends with the new byte at the head).
- R10: An engine load in a cycle with a CPU pop or push ignores the CPU access.
- R11: `flush` in the same cycle as an engine load wins; the buffer ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Push `cpu_wdata` |
| cpu_wdata | input | 8 | Byte to push |
| cpu_rd | input | 1 | Pop the head byte |
| cpu_rdata | output | 8 | Head byte, or 0xFF when empty |
| flush | input | 1 | Empty the buffer |
| eng_load | input | 1 | Engine loads received bytes |
| eng_cnt | input | 3 | Number of bytes moved by the engine |
| eng_data | input | 32 | Received bytes, byte 0 in the low bits |
| has_data | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |

## Verification
The hardest state to reach is a pop and a push landing in one cycle at the edges of the occupancy range: on a full buffer, where the push only succeeds because the pop made room, and on a one-entry or empty buffer, where one flag would be cleared and set again in the same cycle. Directed tasks first fill the buffer to exactly that level with single pushes or an engine load, then raise both strobes in one cycle and drain the buffer byte by byte to prove the order and the flag values. Collisions of flush, engine load and CPU strobes are driven the same way.

// File: rtl/i2c_mdb_pkg.sv
package i2c_mdb_pkg;
  localparam int unsigned MDB_DEPTH = 4;
  localparam int unsigned MDB_W     = 8;

  // occupancy after an optional pop
  function automatic int unsigned f_after_pop(int unsigned c, logic rd);
    return (rd && c != 0) ? c - 1 : c;
  endfunction

  // a push succeeds only when a slot is free after the pop
  function automatic logic f_accepts(int unsigned mid, int unsigned depth, logic wr);
    return wr && (mid < depth);
  endfunction

  // engine count saturates at the depth
  function automatic int unsigned f_clamp(int unsigned n, int unsigned depth);
    return (n > depth) ? depth : n;
  endfunction
endpackage

// File: rtl/mdb_ctrl.sv
module mdb_ctrl
  import i2c_mdb_pkg::*;
#(
  parameter int unsigned DEPTH = MDB_DEPTH,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] load_n,
  output logic [CW-1:0] slot,
  output logic          rd_eff,
  output logic          wr_eff,
  output logic          has_data,
  output logic          full
);
  logic cpu_go;

  assign cpu_go = !flush && !load;
  assign rd_eff = cpu_go && cpu_rd && (cnt != '0);
  assign slot   = CW'(f_after_pop(int'(cnt), cpu_go && cpu_rd));
  assign wr_eff = cpu_go && f_accepts(int'(slot), DEPTH, cpu_wr);
  assign load_n = CW'(f_clamp(int'(load_cnt), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt      <= '0;
      has_data <= 1'b0;
      full     <= 1'b0;
    end else if (load) begin
      cnt      <= load_n;
      has_data <= (load_n != '0);
      full     <= (load_n == CW'(DEPTH));
    end else begin
      cnt <= slot + CW'(wr_eff);
      // pop side first, then push side may set again
      if (wr_eff && slot == '0)                   has_data <= 1'b1;
      else if (rd_eff && cnt == CW'(1))           has_data <= 1'b0;
      if (wr_eff && slot == CW'(DEPTH - 1))       full <= 1'b1;
      else if (rd_eff && cnt == CW'(DEPTH))       full <= 1'b0;
    end
  end

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r3_has_data_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    has_data == (cnt != '0));
  a_r4_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    full == (cnt == CW'(DEPTH)));
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cpu_wr && !cpu_rd && !flush && !load) |=> (full && $stable(cnt)));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && !has_data && !full));
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> (cnt == $past(load_n)));
endmodule

// File: rtl/mdb_store.sv
module mdb_store
  import i2c_mdb_pkg::*;
#(
  parameter int unsigned DEPTH = MDB_DEPTH,
  parameter int unsigned W     = MDB_W,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [CW-1:0]    load_n,
  input  logic [DEPTH*W-1:0] load_data,
  input  logic             shift,
  input  logic             put,
  input  logic [CW-1:0]    slot,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     head
);
  logic [W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] above;
    logic [W-1:0] nxt;
    if (i == DEPTH - 1) begin : g_top
      assign above = '0;
    end else begin : g_mid
      assign above = ent[i+1];
    end

    always_comb begin
      nxt = shift ? above : ent[i];
      if (put && slot == CW'(i)) nxt = wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || flush)  ent[i] <= '0;
      else if (load)        ent[i] <= (load_n > CW'(i)) ? load_data[i*W +: W] : '0;
      else                  ent[i] <= nxt;
    end
  end

  assign head = ent[0];
endmodule

// File: rtl/i2c_mdbuf.sv
module i2c_mdbuf
  import i2c_mdb_pkg::*;
#(
  parameter int unsigned DEPTH = MDB_DEPTH,
  parameter int unsigned W     = MDB_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [W-1:0]       cpu_wdata,
  input  logic               cpu_rd,
  output logic [W-1:0]       cpu_rdata,
  input  logic               flush,
  input  logic               eng_load,
  input  logic [CW-1:0]      eng_cnt,
  input  logic [DEPTH*W-1:0] eng_data,
  output logic               has_data,
  output logic               full
);
  logic [CW-1:0] cnt, load_n, slot;
  logic          rd_eff, wr_eff;
  logic [W-1:0]  head;

  mdb_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk, .rst_n, .flush, .load(eng_load), .load_cnt(eng_cnt),
    .cpu_rd, .cpu_wr, .cnt, .load_n, .slot, .rd_eff, .wr_eff,
    .has_data, .full
  );

  mdb_store #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_store (
    .clk, .rst_n, .flush, .load(eng_load), .load_n, .load_data(eng_data),
    .shift(rd_eff), .put(wr_eff), .slot, .wdata(cpu_wdata), .head
  );

  assign cpu_rdata = (cnt == '0) ? '1 : head;

  a_r6_empty_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !has_data |-> (cpu_rdata == '1));
  a_r6_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_data && cpu_rd && !cpu_wr && !eng_load) |=> !has_data);
  a_r9_full_rdwr_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cpu_rd && cpu_wr && !flush && !eng_load) |=> full);
endmodule

// File: tb/i2c_mdbuf_tb.sv
module i2c_mdbuf_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, flush = 1'b0, eng_load = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [2:0]  eng_cnt = '0;
  logic [31:0] eng_data = '0;
  logic        has_data, full;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mdbuf u_dut (
    .clk, .rst_n, .cpu_wr, .cpu_wdata, .cpu_rd, .cpu_rdata, .flush,
    .eng_load, .eng_cnt, .eng_data, .has_data, .full
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic flags(string tag, logic h, logic f);
    chk({tag, " has_data"}, {7'b0, has_data}, {7'b0, h});
    chk({tag, " full"}, {7'b0, full}, {7'b0, f});
  endtask

  task automatic push(logic [7:0] b);
    cpu_wr = 1'b1; cpu_wdata = b; tick; cpu_wr = 1'b0;
  endtask

  task automatic pop(string tag, logic [7:0] exp);
    cpu_rd = 1'b1; #1 chk(tag, cpu_rdata, exp); tick; cpu_rd = 1'b0;
  endtask

  task automatic load(logic [2:0] n, logic [31:0] d);
    eng_load = 1'b1; eng_cnt = n; eng_data = d; tick; eng_load = 1'b0;
  endtask

  task automatic t_reset;
    flags("R1 reset", 1'b0, 1'b0);
    chk("R1 reset rdata", cpu_rdata, 8'hFF);
  endtask

  task automatic t_order;
    push(8'hA1);
    flags("R3 first push", 1'b1, 1'b0);
    push(8'hB2); push(8'hC3);
    pop("R2 order 0", 8'hA1);
    pop("R2 order 1", 8'hB2);
    flags("R3 one left", 1'b1, 1'b0);
    pop("R2 order 2", 8'hC3);
    flags("R3 drained", 1'b0, 1'b0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) push(8'h40 + 8'(i));
    flags("R4 four held", 1'b1, 1'b1);
    push(8'hEE);
    flags("R5 push on full", 1'b1, 1'b1);
    pop("R5 head kept", 8'h40);
    flags("R4 pop from full", 1'b1, 1'b0);
    pop("R5 e1", 8'h41); pop("R5 e2", 8'h42); pop("R5 e3 no EE", 8'h43);
    pop("R6 empty pop", 8'hFF);
    flags("R6 empty pop flags", 1'b0, 1'b0);
    push(8'h5A);
    pop("R6 nothing changed by empty pop", 8'h5A);
  endtask

  task automatic t_same_cycle;
    push(8'h11);
    cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h22;
    #1 chk("R9 one entry rdata", cpu_rdata, 8'h11);
    tick; cpu_rd = 1'b0; cpu_wr = 1'b0;
    flags("R9 one entry net", 1'b1, 1'b0);
    pop("R9 new head", 8'h22);
    flags("R9 drained", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) push(8'h30 + 8'(i));
    cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h34;
    #1 chk("R9 full rdata", cpu_rdata, 8'h30);
    tick; cpu_rd = 1'b0; cpu_wr = 1'b0;
    flags("R9 full stays full", 1'b1, 1'b1);
    for (int i = 1; i < 5; i++) pop("R9 full drain", 8'h30 + 8'(i));
    cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h55;
    #1 chk("R9 empty rdata", cpu_rdata, 8'hFF);
    tick; cpu_rd = 1'b0; cpu_wr = 1'b0;
    flags("R9 empty net", 1'b1, 1'b0);
    pop("R9 empty then push", 8'h55);
  endtask

  task automatic t_flush;
    push(8'h61); push(8'h62);
    flush = 1'b1; tick; flush = 1'b0;
    flags("R7 flush", 1'b0, 1'b0);
    chk("R7 flush rdata", cpu_rdata, 8'hFF);
    push(8'h66);
    pop("R7 restart at head", 8'h66);
    flags("R7 after", 1'b0, 1'b0);
  endtask

  task automatic t_load;
    load(3'd3, 32'hDD_CC_BB_AA);
    flags("R8 load 3", 1'b1, 1'b0);
    pop("R8 b0", 8'hAA); pop("R8 b1", 8'hBB); pop("R8 b2", 8'hCC);
    flags("R8 load 3 drained", 1'b0, 1'b0);
    load(3'd4, 32'h04_03_02_01);
    flags("R8 load 4", 1'b1, 1'b1);
    load(3'd0, 32'hFFFF_FFFF);
    flags("R8 load 0", 1'b0, 1'b0);
    chk("R8 load 0 rdata", cpu_rdata, 8'hFF);
    load(3'd6, 32'h84_83_82_81);
    flags("R8 load clamp", 1'b1, 1'b1);
    for (int i = 1; i < 5; i++) pop("R8 clamp drain", 8'h80 + 8'(i));
    flags("R8 clamp drained", 1'b0, 1'b0);
  endtask

  task automatic t_prio;
    push(8'h77);
    cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h99;
    load(3'd2, 32'h0000_E2E1);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    flags("R10 load over cpu", 1'b1, 1'b0);
    pop("R10 b0", 8'hE1); pop("R10 b1", 8'hE2);
    flags("R10 no extra", 1'b0, 1'b0);
    flush = 1'b1; load(3'd4, 32'h1234_5678); flush = 1'b0;
    flags("R11 flush over load", 1'b0, 1'b0);
    chk("R11 rdata", cpu_rdata, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_same_cycle();
    t_flush();
    t_load();
    t_prio();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule